// File: doc/BRIEF.md
# Interrupt Priority and Vector Unit

This unit sits beside the sequencer of an 8-bit CPU core. It decides which of three competing events the core services next: an external bus master asking for the bus, a non-maskable interrupt, or a maskable interrupt. For each interrupt it produces the jump target, or in one mode the opcode to execute. The core tells it where the boundaries fall with two one-cycle pulses: one at the end of each machine cycle and one at the end of each instruction. The unit itself does not execute instructions.

A bus request is only honoured at a machine-cycle boundary. While the bus is granted, the unit raises a tri-state enable that floats the address bus, the data bus and the memory, I/O, read and write strobes. The non-maskable input acts on its falling edge, and the edge is held until it is serviced. The maskable input is a low level. It is sampled only at instruction boundaries, and only while the enable flip-flop inside the unit is set.

Accepting a maskable interrupt starts an acknowledge window. The window lasts the base acknowledge length plus two wait states. The byte on the data bus is captured in the last cycle of the window. That byte then becomes one of three results, chosen by the interrupt mode:
- an opcode for the core to execute;
- a fixed vector that ignores the byte;
- a table address built from the I register and the byte.

Top module: `irq_vector_unit`

## Requirements
- R1: `busack_n` goes low in the cycle after a cycle in which `mcycle_end`=1 and `busreq_n`=0. A low `busreq_n` without `mcycle_end` grants nothing.
- R2: While granted, `bus_hiz`=1 and `busack_n`=0. In the cycle after `busreq_n` returns high, both are released (`busack_n`=1, `bus_hiz`=0).
- R3: The bus outranks both interrupts. If a grant is taken in the same cycle as `instr_end`, no service starts. An `instr_end` during a grant starts no service either. A pending NMI is serviced at the first `instr_end` after release.
- R4: A falling edge on `nmi_n` is latched, even from a one-cycle pulse. The next `instr_end` after the edge has registered gives `svc_valid`=1 for one cycle with `svc_type`=1 and `target`=16'h0066, whatever the value of `ie_state`. Holding `nmi_n` low produces no second service.
- R5: When an NMI is pending and the maskable interrupt is also asserted at the same `instr_end`, the NMI is serviced and `inta` stays low. `ie_state` is unchanged, so the maskable interrupt is taken at a later `instr_end`.
- R6: A maskable interrupt (`int_n`=0) is accepted only at `instr_end` with `ie_state`=1. With `ie_state`=0, `inta` stays low.
- R7: Acceptance clears `ie_state` in the next cycle. In that same next cycle `inta` goes high and stays high for 4 cycles (2 base plus 2 wait). In the cycle after `inta` falls, `svc_valid`=1 for one cycle, using the `bus_byte` captured in the last `inta` cycle.
- R8: Mode 1 (`mode_sel`=1) gives `svc_type`=3 and `target`=16'h0038, whatever `bus_byte` holds.
- R9: Mode 2 (`mode_sel`=2) gives `svc_type`=4 and `target`={`i_reg`, `bus_byte`}.
- R10: Mode 0 (`mode_sel`=0) gives `svc_type`=2 and `target`={8'h00, `bus_byte`}, which is the opcode to execute.
- R11: After reset, `ie_state`=0, the mode is 0, `busack_n`=1, `bus_hiz`=0, `inta`=0 and `svc_valid`=0. A mode write with code 3 is ignored and keeps the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busreq_n | input | 1 | Active-low bus request from an external master |
| nmi_n | input | 1 | Non-maskable interrupt, acts on its falling edge |
| int_n | input | 1 | Active-low maskable interrupt level |
| mcycle_end | input | 1 | One-cycle pulse at the end of a machine cycle |
| instr_end | input | 1 | One-cycle pulse at the end of an instruction |
| ie_wr | input | 1 | Write strobe for the enable flip-flop |
| ie_val | input | 1 | Value written to the enable flip-flop |
| mode_wr | input | 1 | Write strobe for the interrupt mode |
| mode_sel | input | 2 | Mode code: 0 opcode, 1 fixed, 2 table; 3 is ignored |
| i_reg | input | 8 | High byte of the table vector |
| bus_byte | input | 8 | Data bus byte supplied during acknowledge |
| busack_n | output | 1 | Active-low bus acknowledge |
| bus_hiz | output | 1 | High while bus and strobes must float |
| inta | output | 1 | High during the interrupt acknowledge window |
| ie_state | output | 1 | Current enable flip-flop state |
| svc_valid | output | 1 | One-cycle strobe: service type and target are valid |
| svc_type | output | 3 | 1 NMI, 2 opcode, 3 fixed vector, 4 table vector |
| target | output | 16 | Jump address, or the opcode in the low byte |

## Verification
The assertions take the following for granted about the inputs:
- `mcycle_end` and `instr_end` are single-cycle pulses.
- `instr_end` is not pulsed while `inta` is high.
- `i_reg` stays stable from acceptance until `svc_valid`.

Under those assumptions, the table-vector check can compare the target's high byte against the live `i_reg`. The stimulus meets them by setting `i_reg`, `bus_byte` and the mode before each boundary pulse and holding them through the whole window. It also waits for each acknowledge to finish before issuing the next `instr_end`, and it lowers `nmi_n` at least one cycle before the boundary that should service it.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
   typedef enum logic [2:0] {
      SVC_NONE   = 3'd0,
      SVC_NMI    = 3'd1,
      SVC_OPCODE = 3'd2,
      SVC_FIXED  = 3'd3,
      SVC_TABLE  = 3'd4
   } svc_e;

   typedef enum logic [1:0] {
      MODE_OPCODE = 2'd0,
      MODE_FIXED  = 2'd1,
      MODE_TABLE  = 2'd2
   } imode_e;
endpackage

// File: rtl/ivu_nmi_latch.sv
module ivu_nmi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   input  logic clear,
   output logic pend
);
   logic prev_q;
   logic fell;

   assign fell = prev_q & ~nmi_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         pend   <= 1'b0;
      end else begin
         prev_q <= nmi_n;
         pend   <= (pend & ~clear) | fell;
      end
   end

   // R4: a latched edge only goes away through a service
   assert_nmi_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(clear));
endmodule

// File: rtl/ivu_bus_grant.sv
module ivu_bus_grant (
   input  logic clk,
   input  logic rst_n,
   input  logic busreq_n,
   input  logic mcycle_end,
   input  logic allow,
   output logic grant_take,
   output logic granted
);
   assign grant_take = !granted && allow && mcycle_end && !busreq_n;

   always_ff @(posedge clk) begin
      if (!rst_n)
         granted <= 1'b0;
      else if (grant_take)
         granted <= 1'b1;
      else if (granted && busreq_n)
         granted <= 1'b0;
   end

   assert_grant_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(granted) |-> $past(mcycle_end && !busreq_n));

   assert_release_on_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(granted) |-> $past(busreq_n));
endmodule

// File: rtl/ivu_ack_seq.sv
module ivu_ack_seq
   import ivu_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned ACK_T   = 4,
   parameter int unsigned NMI_VEC = 'h0066,
   parameter int unsigned FIX_VEC = 'h0038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_nmi,
   input  logic              take_int,
   input  imode_e            mode,
   input  logic [DATA_W-1:0] i_reg,
   input  logic [DATA_W-1:0] bus_byte,
   output logic              inta,
   output logic              svc_valid,
   output svc_e              svc_type,
   output logic [ADDR_W-1:0] target
);
   localparam int unsigned CW = (ACK_T > 1) ? $clog2(ACK_T) : 1;

   if (ADDR_W < 2 * DATA_W) begin : g_chk_width
      $error("ADDR_W must hold the I register and the bus byte");
   end
   if (ACK_T < 1) begin : g_chk_len
      $error("ACK_T must be at least one cycle");
   end

   imode_e mode_q;
   logic   last;

   if (ACK_T == 1) begin : g_single
      assign last = inta;
   end else begin : g_multi
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || take_int)
            cnt <= '0;
         else if (inta)
            cnt <= cnt + 1'b1;
      end
      assign last = inta && (cnt == CW'(ACK_T - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inta      <= 1'b0;
         svc_valid <= 1'b0;
         svc_type  <= SVC_NONE;
         target    <= '0;
         mode_q    <= MODE_OPCODE;
      end else begin
         svc_valid <= 1'b0;
         if (take_nmi) begin
            svc_valid <= 1'b1;
            svc_type  <= SVC_NMI;
            target    <= ADDR_W'(NMI_VEC);
         end else if (take_int) begin
            inta   <= 1'b1;
            mode_q <= mode;
         end else if (last) begin
            inta      <= 1'b0;
            svc_valid <= 1'b1;
            unique case (mode_q)
               MODE_FIXED: begin
                  svc_type <= SVC_FIXED;
                  target   <= ADDR_W'(FIX_VEC);
               end
               MODE_TABLE: begin
                  svc_type <= SVC_TABLE;
                  target   <= ADDR_W'({i_reg, bus_byte});
               end
               default: begin
                  svc_type <= SVC_OPCODE;
                  target   <= ADDR_W'(bus_byte);
               end
            endcase
         end
      end
   end

   assert_result_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inta) |-> (svc_valid && svc_type != SVC_NMI));

   assert_table_high_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_valid && svc_type == SVC_TABLE) |-> (target[2*DATA_W-1:DATA_W] == i_reg));

   assert_nmi_not_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_valid && svc_type == SVC_NMI) |-> !inta);
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import ivu_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned ACK_BASE = 2,
   parameter int unsigned ACK_WAIT = 2,
   parameter int unsigned NMI_VEC  = 'h0066,
   parameter int unsigned FIX_VEC  = 'h0038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busreq_n,
   input  logic              nmi_n,
   input  logic              int_n,
   input  logic              mcycle_end,
   input  logic              instr_end,
   input  logic              ie_wr,
   input  logic              ie_val,
   input  logic              mode_wr,
   input  logic [1:0]        mode_sel,
   input  logic [DATA_W-1:0] i_reg,
   input  logic [DATA_W-1:0] bus_byte,
   output logic              busack_n,
   output logic              bus_hiz,
   output logic              inta,
   output logic              ie_state,
   output logic              svc_valid,
   output logic [2:0]        svc_type,
   output logic [ADDR_W-1:0] target
);
   localparam int unsigned ACK_T = ACK_BASE + ACK_WAIT;

   logic   granted, grant_take, nmi_pend;
   logic   take_ok, take_nmi, take_int;
   logic   ie_q;
   imode_e mode_q;
   svc_e   svc_type_e;

   ivu_nmi_latch u_nmi (
      .clk   (clk),
      .rst_n (rst_n),
      .nmi_n (nmi_n),
      .clear (take_nmi),
      .pend  (nmi_pend)
   );

   ivu_bus_grant u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .busreq_n   (busreq_n),
      .mcycle_end (mcycle_end),
      .allow      (!inta),
      .grant_take (grant_take),
      .granted    (granted)
   );

   assign take_ok  = instr_end && !granted && !inta && !grant_take;
   assign take_nmi = take_ok && nmi_pend;
   assign take_int = take_ok && !nmi_pend && !int_n && ie_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         mode_q <= MODE_OPCODE;
      end else begin
         if (take_int)
            ie_q <= 1'b0;
         else if (ie_wr)
            ie_q <= ie_val;
         if (mode_wr && mode_sel != 2'd3)
            mode_q <= imode_e'(mode_sel);
      end
   end

   ivu_ack_seq #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .ACK_T   (ACK_T),
      .NMI_VEC (NMI_VEC),
      .FIX_VEC (FIX_VEC)
   ) u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_nmi  (take_nmi),
      .take_int  (take_int),
      .mode      (mode_q),
      .i_reg     (i_reg),
      .bus_byte  (bus_byte),
      .inta      (inta),
      .svc_valid (svc_valid),
      .svc_type  (svc_type_e),
      .target    (target)
   );

   assign busack_n = !granted;
   assign bus_hiz  = granted;
   assign ie_state = ie_q;
   assign svc_type = svc_type_e;

   assert_bus_excludes_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(inta && granted));

   assert_int_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inta) |-> $past(!int_n && ie_q && instr_end));

   assert_accept_clears_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inta) |-> !ie_q);
endmodule

// File: tb/sim_irq_vector_unit.sv
module sim_irq_vector_unit;
   logic clk = 1'b0;
   logic rst_n, busreq_n, nmi_n, int_n, mcycle_end, instr_end;
   logic ie_wr, ie_val, mode_wr;
   logic [1:0] mode_sel;
   logic [7:0] i_reg, bus_byte;
   logic busack_n, bus_hiz, inta, ie_state, svc_valid;
   logic [2:0] svc_type;
   logic [15:0] target;
   int n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   irq_vector_unit u0 (
      .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .nmi_n(nmi_n), .int_n(int_n),
      .mcycle_end(mcycle_end), .instr_end(instr_end), .ie_wr(ie_wr), .ie_val(ie_val),
      .mode_wr(mode_wr), .mode_sel(mode_sel), .i_reg(i_reg), .bus_byte(bus_byte),
      .busack_n(busack_n), .bus_hiz(bus_hiz), .inta(inta), .ie_state(ie_state),
      .svc_valid(svc_valid), .svc_type(svc_type), .target(target)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_ie(input logic v);
      ie_wr = 1'b1; ie_val = v; tick(); ie_wr = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      mode_wr = 1'b1; mode_sel = m; tick(); mode_wr = 1'b0;
   endtask

   task automatic boundary();
      instr_end = 1'b1; tick(); instr_end = 1'b0;
   endtask

   task automatic run_int(input string req, input logic [2:0] typ, input logic [15:0] tgt);
      int_n = 1'b0;
      boundary();
      chk({req, " R7 inta rises"}, inta, 1);
      chk({req, " R7 ie cleared"}, ie_state, 0);
      tick(); tick(); tick();
      chk({req, " R7 inta 4th cycle"}, inta, 1);
      chk({req, " R7 no early result"}, svc_valid, 0);
      tick();
      chk({req, " R7 inta falls"}, inta, 0);
      chk({req, " R7 result strobe"}, svc_valid, 1);
      chk({req, " type"}, svc_type, typ);
      chk({req, " target"}, target, tgt);
      int_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      chk("R11 busack_n", busack_n, 1);
      chk("R11 bus_hiz", bus_hiz, 0);
      chk("R11 inta", inta, 0);
      chk("R11 svc_valid", svc_valid, 0);
      chk("R11 ie_state", ie_state, 0);
   endtask

   task automatic t_mode0_default();
      set_ie(1'b1);
      bus_byte = 8'hD7;
      run_int("R10 R11 default mode", 3'd2, 16'h00D7);
   endtask

   task automatic t_ie_off();
      int_n = 1'b0;
      boundary();
      chk("R6 no ack when disabled", inta, 0);
      tick();
      chk("R6 still no ack", inta, 0);
      chk("R6 no service", svc_valid, 0);
      int_n = 1'b1;
   endtask

   task automatic t_mode1();
      set_mode(2'd1); set_ie(1'b1);
      bus_byte = 8'h55;
      run_int("R8 fixed vector", 3'd3, 16'h0038);
   endtask

   task automatic t_mode2();
      set_mode(2'd2); set_ie(1'b1);
      i_reg = 8'h9A; bus_byte = 8'h3C;
      run_int("R9 table vector", 3'd4, 16'h9A3C);
      set_mode(2'd3); set_ie(1'b1);
      i_reg = 8'h12; bus_byte = 8'h34;
      run_int("R11 code 3 ignored", 3'd4, 16'h1234);
   endtask

   task automatic t_nmi();
      set_ie(1'b0);
      nmi_n = 1'b0; tick();
      boundary();
      chk("R4 nmi strobe", svc_valid, 1);
      chk("R4 nmi type", svc_type, 1);
      chk("R4 nmi target", target, 16'h0066);
      chk("R4 nmi no ack", inta, 0);
      tick();
      boundary();
      chk("R4 held level no repeat", svc_valid, 0);
      nmi_n = 1'b1; tick();
      nmi_n = 1'b0; tick(); nmi_n = 1'b1;
      tick(); tick(); tick();
      boundary();
      chk("R4 short pulse latched", svc_valid, 1);
      chk("R4 short pulse target", target, 16'h0066);
   endtask

   task automatic t_nmi_vs_int();
      set_mode(2'd1); set_ie(1'b1);
      nmi_n = 1'b0; tick(); nmi_n = 1'b1;
      int_n = 1'b0;
      boundary();
      chk("R5 nmi wins", svc_type, 1);
      chk("R5 nmi wins strobe", svc_valid, 1);
      chk("R5 no ack", inta, 0);
      chk("R5 ie kept", ie_state, 1);
      tick();
      run_int("R5 int afterwards", 3'd3, 16'h0038);
   endtask

   task automatic t_bus();
      busreq_n = 1'b0; tick(); tick();
      chk("R1 no grant without boundary", busack_n, 1);
      mcycle_end = 1'b1; tick(); mcycle_end = 1'b0;
      chk("R1 granted", busack_n, 0);
      chk("R2 float", bus_hiz, 1);
      tick(); tick();
      chk("R2 held", bus_hiz, 1);
      busreq_n = 1'b1; tick();
      chk("R2 released", busack_n, 1);
      chk("R2 float off", bus_hiz, 0);
   endtask

   task automatic t_bus_prio();
      nmi_n = 1'b0; tick(); nmi_n = 1'b1;
      busreq_n = 1'b0; mcycle_end = 1'b1; instr_end = 1'b1; tick();
      mcycle_end = 1'b0; instr_end = 1'b0;
      chk("R3 bus taken", busack_n, 0);
      chk("R3 nmi deferred", svc_valid, 0);
      boundary();
      chk("R3 no service while granted", svc_valid, 0);
      busreq_n = 1'b1; tick();
      boundary();
      chk("R3 nmi after release", svc_valid, 1);
      chk("R3 nmi type after release", svc_type, 1);
   endtask

   initial begin
      rst_n = 1'b0; busreq_n = 1'b1; nmi_n = 1'b1; int_n = 1'b1;
      mcycle_end = 1'b0; instr_end = 1'b0; ie_wr = 1'b0; ie_val = 1'b0;
      mode_wr = 1'b0; mode_sel = 2'd0; i_reg = 8'h00; bus_byte = 8'h00;
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mode0_default();
      t_ie_off();
      t_mode1();
      t_mode2();
      t_nmi();
      t_nmi_vs_int();
      t_bus();
      t_bus_prio();
      tick();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule